// File: doc/BRIEF.md
# Radio-Control Pulse-Train Frame Decoder

This block turns a demodulated carrier-present flag from a hobby radio-control link into two servo pulse outputs and two held on/off outputs. The transmitter interrupts its carrier with short fixed gaps. Each gap is followed by a carrier interval of variable length, and a long carrier interval closes the frame. A three-bit slot counter steps on every loss of carrier. The first and second slots drive the two servo outputs directly. Each servo pulse therefore lasts the gap plus the carrier interval that follows it.

A frame carries one to four extra fixed pulses after the two variable slots, so the number of carrier losses in a frame ranges from four to seven. A sync timer measures how long the carrier has been present without a break. When that time exceeds a threshold that no channel interval can reach, a read window opens and copies the two low counter bits into the digital outputs. A clear window follows, and it zeroes the counter for the next frame. All timing runs on a tick enable, and every window length is a parameter counted in ticks.

Top module: `rc_frame_decoder`

## Requirements
- R1: Each clock in which `carrier_i` is 0 after having been 1 in the previous clock raises the slot count by exactly one. A rising carrier does not change the count. The count becomes visible one clock after the edge is sampled.
- R2: `servo1_o` is 1 exactly while the count is 1. Its width in clocks equals the first gap plus the first carrier interval.
- R3: `servo2_o` is 1 exactly while the count is 2. Its width equals the second gap plus the second carrier interval.
- R4: Slots 3 and higher drive neither servo output.
- R5: Sync fires when the carrier is sampled present on SYNC_TICKS consecutive ticks. Any clock with the carrier absent restarts the measure, so an interval of SYNC_TICKS-1 ticks never fires it.
- R6: While `tick` is 0, neither the sync timer nor the read and clear windows advance.
- R7: On sync, a read window of READ_TICKS ticks loads `dig_a_o` from count bit 0 and `dig_b_o` from count bit 1. Final counts 4, 5, 6 and 7 give (A,B) = (0,0), (1,0), (0,1) and (1,1).
- R8: After the read window, a clear window of CLEAR_TICKS ticks holds the count at 0, so the next frame starts from slot 0.
- R9: The digital outputs change only inside a read window. They keep their value through any carrier pattern that does not produce a sync.
- R10: The count saturates at 7 and does not wrap, so extra edges cannot make a servo output fire again.
- R11: Synchronous reset `rst` clears the count and both digital outputs, and it holds both servo outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-base enable for the sync timer and the windows |
| carrier_i | input | 1 | Synchronous carrier-present flag, 1 = carrier |
| servo1_o | output | 1 | First analog slot pulse |
| servo2_o | output | 1 | Second analog slot pulse |
| dig_a_o | output | 1 | Held digital channel A |
| dig_b_o | output | 1 | Held digital channel B |

## Verification
The checks assume that `carrier_i` is already synchronous and free of glitches. They also assume that every channel interval stays below the sync threshold, and that the sync interval lasts long enough to cover the read and clear windows. The stimulus keeps gaps at two clocks and channel intervals between one and SYNC_TICKS-1 ticks. It holds each sync interval well past the sum of the three windows. The tick-gating case drops `tick` only while the carrier is steady.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
   localparam int SLOT_W = 3;
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_READ  = 2'd1,
      SEQ_CLEAR = 2'd2
   } seq_state_e;
endpackage

// File: rtl/rcd_edge_counter.sv
module rcd_edge_counter #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             carrier_i,
   input  logic             hold_clr,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic carrier_q;
   logic drop;

   assign drop = carrier_q & ~carrier_i;

   always_ff @(posedge clk) begin
      if (rst) carrier_q <= 1'b0;
      else     carrier_q <= carrier_i;
   end

   always_ff @(posedge clk) begin
      if (rst || hold_clr)            cnt <= '0;
      else if (drop && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
   end

   // R1: count moves only by one step up, or back to zero
   assert_step_R1: assert property (@(posedge clk) disable iff (rst)
      (cnt != $past(cnt)) |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

   // R10: a full count never wraps while no clear is requested
   assert_sat_R10: assert property (@(posedge clk) disable iff (rst)
      (cnt == CNT_MAX && !hold_clr) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/rcd_sync_timer.sv
module rcd_sync_timer #(
   parameter int SYNC_TICKS = 35
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic carrier_i,
   output logic sync_fire
);
   localparam int TW = $clog2(SYNC_TICKS + 1);
   localparam logic [TW-1:0] LIMIT = TW'(SYNC_TICKS);
   localparam logic [TW-1:0] LAST  = TW'(SYNC_TICKS - 1);

   generate
      if (SYNC_TICKS < 2) begin : g_bad_sync
         $error("SYNC_TICKS must be at least 2");
      end
   endgenerate

   logic [TW-1:0] run;

   always_ff @(posedge clk) begin
      if (rst || !carrier_i) begin
         run       <= '0;
         sync_fire <= 1'b0;
      end else begin
         sync_fire <= tick && (run == LAST);
         if (tick && run != LIMIT) run <= run + TW'(1);
      end
   end

   // R5: sync only follows a clock with carrier present
   assert_fire_R5: assert property (@(posedge clk) disable iff (rst)
      sync_fire |-> $past(carrier_i));

   // R5: one pulse per long interval
   assert_once_R5: assert property (@(posedge clk) disable iff (rst)
      sync_fire |=> !sync_fire);

   // R6: no progress without a tick
   assert_gate_R6: assert property (@(posedge clk) disable iff (rst)
      (!tick && carrier_i) |=> $stable(run));
endmodule

// File: rtl/rcd_oneshot_seq.sv
module rcd_oneshot_seq
   import rcd_pkg::*;
#(
   parameter int READ_TICKS  = 100,
   parameter int CLEAR_TICKS = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic sync_fire,
   output logic read_en,
   output logic clr_en
);
   localparam int MAXW = (READ_TICKS > CLEAR_TICKS) ? READ_TICKS : CLEAR_TICKS;
   localparam int TW   = $clog2(MAXW + 1);

   generate
      if (READ_TICKS < 1 || CLEAR_TICKS < 1) begin : g_bad_win
         $error("window lengths must be at least 1");
      end
   endgenerate

   seq_state_e    st;
   logic [TW-1:0] left;

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= SEQ_IDLE;
         left <= '0;
      end else begin
         unique case (st)
            SEQ_IDLE: begin
               if (sync_fire) begin
                  st   <= SEQ_READ;
                  left <= TW'(READ_TICKS);
               end
            end
            SEQ_READ: begin
               if (tick) begin
                  if (left == TW'(1)) begin
                     st   <= SEQ_CLEAR;
                     left <= TW'(CLEAR_TICKS);
                  end else begin
                     left <= left - TW'(1);
                  end
               end
            end
            SEQ_CLEAR: begin
               if (tick) begin
                  if (left == TW'(1)) st <= SEQ_IDLE;
                  else                left <= left - TW'(1);
               end
            end
            default: st <= SEQ_IDLE;
         endcase
      end
   end

   assign read_en = (st == SEQ_READ);
   assign clr_en  = (st == SEQ_CLEAR);

   // R7: sync in idle opens the read window
   assert_read_R7: assert property (@(posedge clk) disable iff (rst)
      (st == SEQ_IDLE && sync_fire) |=> read_en);

   // R8: a closing read window hands over to the clear window
   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(read_en) |-> clr_en);
endmodule

// File: rtl/rc_frame_decoder.sv
module rc_frame_decoder
   import rcd_pkg::*;
#(
   parameter int SYNC_TICKS  = 35,
   parameter int READ_TICKS  = 100,
   parameter int CLEAR_TICKS = 100,
   parameter int N_ANALOG    = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic carrier_i,
   output logic servo1_o,
   output logic servo2_o,
   output logic dig_a_o,
   output logic dig_b_o
);
   localparam int SLOTS = (1 << SLOT_W) - 1;

   generate
      if (N_ANALOG != 2 || N_ANALOG >= SLOTS) begin : g_bad_analog
         $error("N_ANALOG must be 2");
      end
   endgenerate

   logic [SLOT_W-1:0]   cnt;
   logic                sync_fire;
   logic                read_en;
   logic                clr_en;
   logic [N_ANALOG-1:0] servo_v;

   rcd_edge_counter #(.CNT_W(SLOT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .carrier_i (carrier_i),
      .hold_clr  (clr_en),
      .cnt       (cnt)
   );

   rcd_sync_timer #(.SYNC_TICKS(SYNC_TICKS)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .carrier_i (carrier_i),
      .sync_fire (sync_fire)
   );

   rcd_oneshot_seq #(.READ_TICKS(READ_TICKS), .CLEAR_TICKS(CLEAR_TICKS)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .sync_fire (sync_fire),
      .read_en   (read_en),
      .clr_en    (clr_en)
   );

   generate
      for (genvar i = 0; i < N_ANALOG; i++) begin : g_slot
         assign servo_v[i] = !rst && (cnt == SLOT_W'(i + 1));
      end
   endgenerate

   assign servo1_o = servo_v[0];
   assign servo2_o = servo_v[1];

   always_ff @(posedge clk) begin
      if (rst) begin
         dig_a_o <= 1'b0;
         dig_b_o <= 1'b0;
      end else if (read_en) begin
         dig_a_o <= cnt[0];
         dig_b_o <= cnt[1];
      end
   end

   // R9: digital outputs move only during a read window
   assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !read_en |=> $stable({dig_a_o, dig_b_o}));

   // R3: the second slot pulse starts as the first one ends
   assert_order_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(servo2_o) |-> $fell(servo1_o));
endmodule

// File: tb/sim_rc_frame_decoder.sv
module sim_rc_frame_decoder;
   localparam int SYNC  = 6;
   localparam int READ  = 4;
   localparam int CLEAR = 3;
   localparam int GAP   = 2;
   localparam int FIX   = 2;
   localparam int HOLD  = 20;

   // {w1[13:10], w2[9:6], gaps[5:2], expB[1], expA[0]}
   localparam logic [13:0] VEC [5] = '{
      {4'd1, 4'd5, 4'd4, 2'b00},
      {4'd3, 4'd2, 4'd5, 2'b01},
      {4'd5, 4'd4, 4'd6, 2'b10},
      {4'd2, 4'd1, 4'd7, 2'b11},
      {4'd4, 4'd3, 4'd6, 2'b10}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b1;
   logic carrier = 1'b1;
   logic servo1, servo2, dig_a, dig_b;
   int total = 0;
   int bad = 0;
   int h1 = 0;
   int h2 = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rc_frame_decoder #(.SYNC_TICKS(SYNC), .READ_TICKS(READ), .CLEAR_TICKS(CLEAR)) u0 (
      .clk(clk), .rst(rst), .tick(tick), .carrier_i(carrier),
      .servo1_o(servo1), .servo2_o(servo2), .dig_a_o(dig_a), .dig_b_o(dig_b)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input logic c);
      carrier = c;
      @(posedge clk);
      #1;
      if (servo1) h1++;
      if (servo2) h2++;
   endtask

   task automatic frame(input int w1, input int w2, input int gaps);
      h1 = 0;
      h2 = 0;
      for (int g = 0; g < gaps; g++) begin
         repeat (GAP) step(1'b0);
         if (g < gaps - 1) repeat ((g == 0) ? w1 : (g == 1) ? w2 : FIX) step(1'b1);
      end
      repeat (HOLD) step(1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R11 reset servo1", servo1, 0);
      chk("R11 reset servo2", servo2, 0);
      chk("R11 reset dig_a", dig_a, 0);
      chk("R11 reset dig_b", dig_b, 0);
      rst = 1'b0;
      repeat (HOLD) step(1'b1);

      for (int i = 0; i < 5; i++) begin
         frame(int'(VEC[i][13:10]), int'(VEC[i][9:6]), int'(VEC[i][5:2]));
         chk("R2 servo1 width", h1, GAP + int'(VEC[i][13:10]));
         chk("R3 servo2 width", h2, GAP + int'(VEC[i][9:6]));
         chk("R7 dig_a", dig_a, int'(VEC[i][0]));
         chk("R7 dig_b", dig_b, int'(VEC[i][1]));
         chk("R8 count cleared servo1", servo1, 0);
      end

      // R10 / R4: ten drops without sync, servo must not re-fire
      frame(3, 2, 10);
      chk("R10 servo1 width", h1, GAP + 3);
      chk("R4 servo2 width", h2, GAP + 2);
      chk("R10 dig_a", dig_a, 1);
      chk("R10 dig_b", dig_b, 1);

      // R5: intervals of SYNC-1 ticks must not close the frame
      frame(SYNC - 1, SYNC - 1, 6);
      chk("R5 servo1 width", h1, GAP + SYNC - 1);
      chk("R5 servo2 width", h2, GAP + SYNC - 1);
      chk("R1 dig_a", dig_a, 0);
      chk("R1 dig_b", dig_b, 1);

      // R9: carrier lost for long, outputs held
      repeat (40) step(1'b0);
      chk("R9 dig_a held", dig_a, 0);
      chk("R9 dig_b held", dig_b, 1);
      chk("R1 servo1 after one drop", servo1, 1);

      // R6: no tick, no sync
      tick = 1'b0;
      repeat (30) step(1'b1);
      chk("R6 dig_a frozen", dig_a, 0);
      chk("R6 dig_b frozen", dig_b, 1);
      chk("R6 servo1 not cleared", servo1, 1);
      tick = 1'b1;
      repeat (HOLD) step(1'b1);
      chk("R5 sync dig_a", dig_a, 1);
      chk("R5 sync dig_b", dig_b, 0);
      chk("R8 servo1 cleared", servo1, 0);

      // R11: reset in mid frame
      step(1'b0);
      chk("R2 servo1 on drop", servo1, 1);
      rst = 1'b1;
      step(1'b0);
      rst = 1'b0;
      step(1'b0);
      chk("R11 mid reset servo1", servo1, 0);
      chk("R11 mid reset dig_a", dig_a, 0);
      chk("R11 mid reset dig_b", dig_b, 0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog act=0 exp=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule